// File: doc/BRIEF.md
# Command Queue Host Interface

This block sits between a 16-bit register bus and a drawing engine. Software cannot write a 32-bit command in one bus cycle, so it writes two halves. The upper half goes first and is held in a latch. Writing the lower half joins the two halves into one command word and enqueues it in a local command queue. The engine drains the queue through a valid/ready stream of 32-bit words.

Software never looks at a full flag. Before it writes a batch of commands, it reads how many commands are still waiting, or how many slots are free, and it waits until the batch fits. The usable capacity of the queue can be set below its physical depth. A clear strobe throws away everything that is waiting. A small interrupt block records two events in a status register, command completion and a dropped push. Each status bit is cleared by writing one to it, and an enable register gates both bits onto a single interrupt line.

Top module: `cmdq_host`

## Requirements
- R1: After reset the following values read back: pending count 0 (select 4), free count DEPTH (select 5), size DEPTH-1 (select 2), status 0 (select 6) and enable 0 (select 7). After reset `irq` and `cmd_valid` are low.
- R2: A write to select 0 stores the upper command half and enqueues nothing. A later write to select 1 enqueues the command {upper, written data}, with the upper half in bits 31:16.
- R3: Commands leave on `cmd_data` in the order they were enqueued. A word leaves in each cycle in which `cmd_valid` and `cmd_ready` are both high.
- R4: The pending count equals the number of enqueued commands not yet accepted by the engine. The free count equals (size + 1) minus the pending count, or 0 when the pending count is larger.
- R5: Writing N to select 2 sets the usable capacity to N+1 entries, and the value reads back at select 2.
- R6: A push that arrives when the pending count has reached the capacity is discarded, and it sets status bit 1 until software clears that bit.
- R7: A write to select 3 with bit 0 set empties the queue. A write to select 3 with bit 0 clear changes nothing.
- R8: A pulse on `done_pulse` sets status bit 0. Writing select 6 clears exactly the status bits that are 1 in the written data. A new event in the same cycle wins over the clear.
- R9: `irq` is high exactly when some status bit is set and its enable bit (select 7, bits 1:0) is also set.
- R10: If a push is accepted in the same cycle as a pop, the pending count does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_wr_sel | input | 3 | Register select for the write |
| bus_wr_data | input | 16 | Write data |
| bus_rd_sel | input | 3 | Register select for the read |
| bus_rd_data | output | 16 | Read data (combinational from `bus_rd_sel`) |
| cmd_valid | output | 1 | A command is waiting at the queue head |
| cmd_ready | input | 1 | Engine accepts the head command |
| cmd_data | output | 32 | Head command word |
| done_pulse | input | 1 | Engine signals that a command has completed |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with DEPTH = 8 and the 16-bit bus width. A queue that small reaches full, overflow and pointer wrap-around after only a few dozen pushes, so both the reduced capacity set through the size register and the physical boundary are exercised. A scoreboard checks the order of drained words across the wrap. It also checks that a dropped push never appears at the output. A push and a pop in the same cycle are checked against the pending count.

// File: rtl/cmdq_pkg.sv
// Package cmdq_pkg
// Shared register selects and status bit positions for the command queue
// host interface. Assumes a 3-bit register select on the bus.
package cmdq_pkg;
    typedef enum logic [2:0] {
        SEL_CMD_UPPER = 3'd0,
        SEL_CMD_LOWER = 3'd1,
        SEL_SIZE      = 3'd2,
        SEL_FLUSH     = 3'd3,
        SEL_PENDING   = 3'd4,
        SEL_FREE      = 3'd5,
        SEL_STATUS    = 3'd6,
        SEL_ENABLE    = 3'd7
    } reg_sel_e;

    localparam int EVT_COUNT = 2;
    localparam int EVT_DONE  = 0;
    localparam int EVT_DROP  = 1;
endpackage

// File: rtl/cmdq_assemble.sv
// Module cmdq_assemble
// Joins two bus halfwords into one command word. The upper half is held
// in a register. A write of the lower half produces a one-cycle push
// together with the joined word. Assumes the upper half is written first.
module cmdq_assemble
    import cmdq_pkg::*;
#(
    parameter int HALF_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [2:0]            wr_sel,
    input  logic [HALF_W-1:0]     wr_data,
    output logic                  push_o,
    output logic [2*HALF_W-1:0]   word_o
);
    logic [HALF_W-1:0] upper_q;

    // Hold the upper half until the lower half arrives.
    always_ff @(posedge clk) begin
        if (!rst_n)
            upper_q <= '0;
        else if (wr_en && reg_sel_e'(wr_sel) == SEL_CMD_UPPER)
            upper_q <= wr_data;
    end

    // The lower-half write is the push event.
    always_comb begin
        push_o = wr_en && (reg_sel_e'(wr_sel) == SEL_CMD_LOWER);
        word_o = {upper_q, wr_data};
    end

    AST_UPPER_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel_e'(wr_sel) == SEL_CMD_UPPER) |-> !push_o); // R2
endmodule

// File: rtl/cmdq_fifo.sv
// Module cmdq_fifo
// Command queue with a physical depth of DEPTH and a run-time capacity
// limit. A push is accepted only while the count is below the limit.
// Assumes DEPTH is a power of two, so the pointers wrap naturally.
// Flush has priority over push and pop.
module cmdq_fifo #(
    parameter int DEPTH  = 512,
    parameter int DATA_W = 32,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [DATA_W-1:0] push_data_i,
    input  logic              flush_i,
    input  logic [CW-1:0]     limit_i,
    input  logic              ready_i,
    output logic              valid_o,
    output logic [DATA_W-1:0] data_o,
    output logic [CW-1:0]     count_o,
    output logic              drop_o
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr_q, rd_ptr_q;
    logic [CW-1:0]     count_q;
    logic              accept, pop;

    // Accept and drop decisions for this cycle.
    always_comb begin
        accept  = push_i && !flush_i && (count_q < limit_i);
        drop_o  = push_i && !flush_i && (count_q >= limit_i);
        valid_o = (count_q != '0);
        pop     = valid_o && ready_i && !flush_i;
        data_o  = mem[rd_ptr_q];
        count_o = count_q;
    end

    // Storage write on an accepted push.
    always_ff @(posedge clk) begin
        if (accept)
            mem[wr_ptr_q] <= push_data_i;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (accept) wr_ptr_q <= wr_ptr_q + 1'b1;
            if (pop)    rd_ptr_q <= rd_ptr_q + 1'b1;
            count_q <= count_q + CW'(accept) - CW'(pop);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CW'(DEPTH)); // R5
    AST_DROP_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_o && !pop) |=> $stable(count_q)); // R6
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (count_q == '0)); // R7
    AST_PUSH_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && pop) |=> (count_q == $past(count_q))); // R10
endmodule

// File: rtl/cmdq_irq.sv
// Module cmdq_irq
// Event status register with write-one-to-clear bits and an enable mask.
// A new event wins over a clear in the same cycle. Assumes the event
// inputs are single-cycle pulses.
module cmdq_irq #(
    parameter int NEVT = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NEVT-1:0] event_i,
    input  logic            clr_we,
    input  logic [NEVT-1:0] clr_data,
    input  logic            en_we,
    input  logic [NEVT-1:0] en_data,
    output logic [NEVT-1:0] status_o,
    output logic [NEVT-1:0] enable_o,
    output logic            irq_o
);
    logic [NEVT-1:0] status_q, enable_q;

    // Sticky status with write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            status_q <= '0;
        else
            status_q <= (status_q & ~(clr_we ? clr_data : '0)) | event_i;
    end

    // Enable mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            enable_q <= '0;
        else if (en_we)
            enable_q <= en_data;
    end

    // Gated interrupt line.
    always_comb begin
        status_o = status_q;
        enable_o = enable_q;
        irq_o    = |(status_q & enable_q);
    end

    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        event_i[0] |=> status_q[0]); // R8
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && clr_data[0] && !event_i[0]) |=> !status_q[0]); // R8
endmodule

// File: rtl/cmdq_host.sv
// Module cmdq_host
// Register front end for the command queue. It decodes bus writes into
// command halves, size, flush, status clear and enable. It serves the
// read mux and computes the free count. Assumes DEPTH is a power of two
// and no larger than 2**15, so the counts fit the read data.
module cmdq_host
    import cmdq_pkg::*;
#(
    parameter int DEPTH  = 512,
    parameter int HALF_W = 16,
    localparam int CMD_W = 2 * HALF_W,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic [2:0]        bus_wr_sel,
    input  logic [HALF_W-1:0] bus_wr_data,
    input  logic [2:0]        bus_rd_sel,
    output logic [HALF_W-1:0] bus_rd_data,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [CMD_W-1:0]  cmd_data,
    input  logic              done_pulse,
    output logic              irq
);
    logic             push;
    logic [CMD_W-1:0] push_word;
    logic [AW-1:0]    size_q;
    logic [CW-1:0]    limit, count, free_cnt;
    logic             drop, flush, clr_we, en_we;
    logic [EVT_COUNT-1:0] evt, status, enable;

    cmdq_assemble #(.HALF_W(HALF_W)) u_assemble (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr_en), .wr_sel(bus_wr_sel),
        .wr_data(bus_wr_data), .push_o(push), .word_o(push_word)
    );

    // Capacity register, reset to the full physical depth.
    always_ff @(posedge clk) begin
        if (!rst_n)
            size_q <= AW'(DEPTH - 1);
        else if (bus_wr_en && reg_sel_e'(bus_wr_sel) == SEL_SIZE)
            size_q <= bus_wr_data[AW-1:0];
    end

    // Write strobes and the derived limit.
    always_comb begin
        flush  = bus_wr_en && reg_sel_e'(bus_wr_sel) == SEL_FLUSH && bus_wr_data[0];
        clr_we = bus_wr_en && reg_sel_e'(bus_wr_sel) == SEL_STATUS;
        en_we  = bus_wr_en && reg_sel_e'(bus_wr_sel) == SEL_ENABLE;
        limit  = CW'(size_q) + 1'b1;
        free_cnt = (limit > count) ? (limit - count) : '0;
        evt    = '0;
        evt[EVT_DONE] = done_pulse;
        evt[EVT_DROP] = drop;
    end

    cmdq_fifo #(.DEPTH(DEPTH), .DATA_W(CMD_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push_i(push), .push_data_i(push_word),
        .flush_i(flush), .limit_i(limit), .ready_i(cmd_ready),
        .valid_o(cmd_valid), .data_o(cmd_data), .count_o(count), .drop_o(drop)
    );

    cmdq_irq #(.NEVT(EVT_COUNT)) u_irq (
        .clk(clk), .rst_n(rst_n), .event_i(evt),
        .clr_we(clr_we), .clr_data(bus_wr_data[EVT_COUNT-1:0]),
        .en_we(en_we), .en_data(bus_wr_data[EVT_COUNT-1:0]),
        .status_o(status), .enable_o(enable), .irq_o(irq)
    );

    // Read mux.
    always_comb begin
        case (reg_sel_e'(bus_rd_sel))
            SEL_SIZE:    bus_rd_data = HALF_W'(size_q);
            SEL_PENDING: bus_rd_data = HALF_W'(count);
            SEL_FREE:    bus_rd_data = HALF_W'(free_cnt);
            SEL_STATUS:  bus_rd_data = HALF_W'(status);
            SEL_ENABLE:  bus_rd_data = HALF_W'(enable);
            default:     bus_rd_data = '0;
        endcase
    end

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (enable != '0)); // R9
    AST_VALID_MEANS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (count != '0)); // R4
endmodule

// File: tb/cmdq_host_bench.sv
`timescale 1ns/1ps
module cmdq_host_bench;
    localparam int DEPTH = 8;
    localparam logic [2:0] S_UP = 3'd0, S_LO = 3'd1, S_SIZE = 3'd2, S_FLUSH = 3'd3,
                           S_PEND = 3'd4, S_FREE = 3'd5, S_STAT = 3'd6, S_EN = 3'd7;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        bus_wr_en = 1'b0;
    logic [2:0]  bus_wr_sel = '0;
    logic [15:0] bus_wr_data = '0;
    logic [2:0]  bus_rd_sel = '0;
    logic [15:0] bus_rd_data;
    logic        cmd_valid;
    logic        cmd_ready = 1'b0;
    logic [31:0] cmd_data;
    logic        done_pulse = 1'b0;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    logic [31:0] exp_q[$];

    cmdq_host #(.DEPTH(DEPTH), .HALF_W(16)) u_cmdq_host (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_wr_sel(bus_wr_sel),
        .bus_wr_data(bus_wr_data), .bus_rd_sel(bus_rd_sel), .bus_rd_data(bus_rd_data),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
        .done_pulse(done_pulse), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: compare each drained word with the scoreboard head.
    always @(negedge clk) begin
        #3;
        if (rst_n && cmd_valid && cmd_ready) begin
            if (exp_q.size() == 0) begin
                checks++;
                fails++;
                $display("FAIL R3 unexpected word actual=%h expected=none", cmd_data);
            end else begin
                check("R3 drain order", cmd_data, exp_q.pop_front());
            end
        end
    end

    task automatic wr(input logic [2:0] sel, input logic [15:0] data);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_wr_sel = sel; bus_wr_data = data;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] sel, output logic [15:0] val);
        @(negedge clk);
        bus_rd_sel = sel;
        #1;
        val = bus_rd_data;
    endtask

    // Driver: enqueue one command and record it when it should be kept.
    task automatic push_cmd(input logic [15:0] up, input logic [15:0] lo, input bit keep);
        wr(S_UP, up);
        wr(S_LO, lo);
        if (keep) exp_q.push_back({up, lo});
    endtask

    task automatic drain;
        cmd_ready = 1'b1;
        for (int i = 0; i < 200 && exp_q.size() != 0; i++) @(negedge clk);
        repeat (2) @(negedge clk);
        cmd_ready = 1'b0;
        check("R3 scoreboard empty", 32'(exp_q.size()), 32'd0);
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        #2_000_000;
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        rd(S_PEND, v); check("R1 pending", 32'(v), 32'd0);
        rd(S_FREE, v); check("R1 free", 32'(v), 32'(DEPTH));
        rd(S_SIZE, v); check("R1 size", 32'(v), 32'(DEPTH - 1));
        rd(S_STAT, v); check("R1 status", 32'(v), 32'd0);
        rd(S_EN, v);   check("R1 enable", 32'(v), 32'd0);
        check("R1 irq", 32'(irq), 32'd0);
        check("R1 valid", 32'(cmd_valid), 32'd0);

        // R2 the upper half alone does not enqueue
        wr(S_UP, 16'hA1B2);
        rd(S_PEND, v); check("R2 upper only", 32'(v), 32'd0);
        wr(S_LO, 16'hC3D4);
        exp_q.push_back(32'hA1B2C3D4);
        rd(S_PEND, v); check("R2 after lower", 32'(v), 32'd1);
        check("R2 joined word", cmd_data, 32'hA1B2C3D4);

        // R4 pending and free counts
        for (int i = 0; i < 3; i++) push_cmd(16'h1000 + 16'(i), 16'h2000 + 16'(i), 1'b1);
        rd(S_PEND, v); check("R4 pending", 32'(v), 32'd4);
        rd(S_FREE, v); check("R4 free", 32'(v), 32'(DEPTH - 4));
        drain();                                                    // R3
        rd(S_PEND, v); check("R4 pending after drain", 32'(v), 32'd0);

        // R3 streaming with the engine always ready, past pointer wrap
        cmd_ready = 1'b1;
        for (int i = 0; i < 12; i++) push_cmd(16'h5500 + 16'(i), 16'hAA00 + 16'(i), 1'b1);
        drain();

        // R10 push and pop in the same cycle
        push_cmd(16'h0101, 16'h0202, 1'b1);
        push_cmd(16'h0303, 16'h0404, 1'b1);
        wr(S_UP, 16'h0505);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_wr_sel = S_LO; bus_wr_data = 16'h0606; cmd_ready = 1'b1;
        exp_q.push_back(32'h05050606);
        @(negedge clk);
        bus_wr_en = 1'b0; cmd_ready = 1'b0;
        rd(S_PEND, v); check("R10 count held", 32'(v), 32'd2);
        drain();

        // R5 reduced capacity and R6 drop on full
        wr(S_SIZE, 16'd3);
        rd(S_SIZE, v); check("R5 size readback", 32'(v), 32'd3);
        rd(S_FREE, v); check("R5 free at size 3", 32'(v), 32'd4);
        for (int i = 0; i < 5; i++) push_cmd(16'h7700 + 16'(i), 16'h8800 + 16'(i), i < 4);
        rd(S_PEND, v); check("R5 capped pending", 32'(v), 32'd4);
        rd(S_FREE, v); check("R5 free when full", 32'(v), 32'd0);
        rd(S_STAT, v); check("R6 drop flag", 32'(v), 32'h2);
        drain();                                                    // R6 dropped word absent
        rd(S_STAT, v); check("R6 flag sticky", 32'(v), 32'h2);
        wr(S_STAT, 16'h2);
        rd(S_STAT, v); check("R6 flag cleared", 32'(v), 32'h0);
        wr(S_SIZE, 16'(DEPTH - 1));

        // R7 flush
        push_cmd(16'h9001, 16'h9002, 1'b1);
        push_cmd(16'h9003, 16'h9004, 1'b1);
        wr(S_FLUSH, 16'h0);
        rd(S_PEND, v); check("R7 flush bit clear ignored", 32'(v), 32'd2);
        wr(S_FLUSH, 16'h1);
        exp_q.delete();
        rd(S_PEND, v); check("R7 flushed", 32'(v), 32'd0);
        check("R7 valid low", 32'(cmd_valid), 32'd0);
        push_cmd(16'hBEEF, 16'hCAFE, 1'b1);
        drain();

        // R8 completion status and R9 gating
        @(negedge clk); done_pulse = 1'b1;
        @(negedge clk); done_pulse = 1'b0;
        rd(S_STAT, v); check("R8 done set", 32'(v), 32'h1);
        check("R9 masked", 32'(irq), 32'd0);
        wr(S_STAT, 16'h0);
        rd(S_STAT, v); check("R8 zero write keeps", 32'(v), 32'h1);
        wr(S_EN, 16'h1);
        #1; check("R9 enabled", 32'(irq), 32'd1);
        wr(S_EN, 16'h2);
        #1; check("R9 other bit enabled only", 32'(irq), 32'd0);
        wr(S_EN, 16'h1);
        wr(S_STAT, 16'h1);
        rd(S_STAT, v); check("R8 w1c", 32'(v), 32'h0);
        check("R9 irq drops", 32'(irq), 32'd0);

        finish_run();
    end
endmodule